// File: doc/BRIEF.md
# Flash Status Word Generator

This block forms the byte that a host sees when it reads a flash array while the embedded program/erase engine owns it. A separate controller tells the block which operation is in flight (program, whole-array erase, selective block erase, erase suspended, or plain array read). It also supplies the block index decoded from the read address, the set of blocks selected for erase, the set of blocks that failed, bit 7 of the word being programmed, and a flag that marks whether the erase has left its selection window. Each rising edge of the read strobe produces one result word. Depending on the mode, that word is either a status byte or the array data passed through.

Two alternating flags let software track progress. The primary one alternates on every read while the engine runs and freezes when an erase is suspended. The secondary one alternates only when the read lands in a block that is being erased, or in a block that failed after an erase error. Software can therefore tell erasing blocks from idle ones and locate a faulty block. A sticky fault flag holds a failure until the controller clears it. An active-low busy output models a wired-AND ready line.

Top module: `fsw_status_gen`

## Requirements
- R1: With op_kind = 1 (program), each read returns bit 7 = inverse of prog_bit7, bit 6 = primary toggle, bit 5 = fault flag, and bits 4, 3, 2, 1 and 0 = 0.
- R2: With op_kind = 2 (chip erase) or 3 (block erase), bit 7 of the result is 0. With op_kind = 4 (suspended), a read inside an erase-selected block returns bit 7 = 1, bit 6 = frozen primary toggle, bit 5 = 0, bit 3 = 1, bit 2 = secondary toggle, and all other bits 0.
- R3: The primary toggle (bit 6) advances once per rising edge of rd_stb while op_kind is 1, 2 or 3, however long the strobe is held. A read returns the value held before that read's advance. The toggle holds while op_kind = 4, and both toggles return to 0 while op_kind is 0 or 5 to 7.
- R4: The fault flag sets the clock after fail_set and stays set until clr_err, which wins over fail_set. It appears on bit 5 in op_kind 1, 2 and 3.
- R5: Bit 3 reads 1 for op_kind 2 and 4 (erasing block). For op_kind 3 it reads erase_started, and for op_kind 1 it reads 0.
- R6: During op_kind 2 or 3 with no fault, the secondary toggle (bit 2) advances on a read only when the addressed block is erase-selected. Chip erase counts every block as selected. Reads elsewhere leave it unchanged. It never advances in op_kind 1.
- R7: During op_kind 2 or 3 with the fault flag set, the secondary toggle advances only for reads of blocks whose fail_mask bit is 1.
- R8: busy_n is 0 on the clock after op_kind is 1, 2 or 3, and 1 after any other op_kind. It is 1 out of reset.
- R9: With op_kind 0 or 5 to 7, or op_kind 4 addressing a block that is not selected for erase, the result is array_data. A block index of NUM_BLOCKS or more counts as not selected.
- R10: rd_data updates on the clock edge where rd_stb is seen rising, and holds its value at all other times. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_kind | input | 3 | 0 read, 1 program, 2 chip erase, 3 block erase, 4 erase suspended |
| rd_stb | input | 1 | Read strobe; a rising edge is one read |
| rd_block | input | BLK_W | Block index of the read address |
| erase_mask | input | NUM_BLOCKS | Blocks selected for erase |
| fail_mask | input | NUM_BLOCKS | Blocks that failed to erase |
| prog_bit7 | input | 1 | Bit 7 of the word being programmed |
| erase_started | input | 1 | Block erase has left its selection window |
| fail_set | input | 1 | Pulse: the engine detected a failure |
| clr_err | input | 1 | Pulse: read/reset clears the fault flag |
| array_data | input | 8 | Array data for the current read address |
| rd_data | output | 8 | Result word of the last read |
| busy_n | output | 1 | Active-low busy |

## Verification
The hardest case to reach is the secondary toggle after an erase fault. It needs a block erase running, a fault injected, and then reads that alternate between failed, erase-selected-but-good, and idle blocks. Only the failed blocks may move bit 2. The stimulus gets there with a dedicated phase that sets fail_mask to a subset of erase_mask, pulses fail_set, and then reads each block twice. A held strobe phase and a suspend/resume phase show that the primary toggle counts edges rather than clocks and freezes across suspension. A randomized phase then mixes modes and masks on every cycle against the bench model.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

    typedef enum logic [2:0] {
        OP_READ = 3'd0,
        OP_PROG = 3'd1,
        OP_CHIP = 3'd2,
        OP_BLK  = 3'd3,
        OP_SUSP = 3'd4
    } op_e;

    localparam int WORD_W  = 8;
    localparam int B_POLL  = 7;
    localparam int B_TOG   = 6;
    localparam int B_FAULT = 5;
    localparam int B_TMR   = 3;
    localparam int B_ALT   = 2;

    function automatic logic op_is_busy(input logic [2:0] k);
        return (k == OP_PROG) || (k == OP_CHIP) || (k == OP_BLK);
    endfunction

    function automatic logic op_is_active(input logic [2:0] k);
        return op_is_busy(k) || (k == OP_SUSP);
    endfunction

endpackage

// File: rtl/fsw_blk_sel.sv
module fsw_blk_sel #(
    parameter int NUM_BLOCKS = 7,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic [BLK_W-1:0]      rd_block,
    input  logic [NUM_BLOCKS-1:0] erase_mask,
    input  logic [NUM_BLOCKS-1:0] fail_mask,
    input  logic                  all_sel,
    output logic                  in_erase,
    output logic                  in_fail
);
    logic [NUM_BLOCKS-1:0] hit;

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_dec
        assign hit[i] = (rd_block == BLK_W'(i));
    end

    always_comb begin
        in_erase = all_sel ? 1'b1 : |(hit & erase_mask);
        in_fail  = |(hit & fail_mask);
    end
endmodule

// File: rtl/fsw_toggle.sv
module fsw_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic q
);
    typedef struct packed {
        logic bit_v;
    } tog_t;

    tog_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.bit_v = 1'b0;
        end else if (adv) begin
            st_d.bit_v = ~st_q.bit_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.bit_v;
endmodule

// File: rtl/fsw_err_latch.sv
module fsw_err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    typedef struct packed {
        logic flag;
    } err_t;

    err_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)      st_d.flag = 1'b0;
        else if (set) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.flag;
endmodule

// File: rtl/fsw_status_gen.sv
module fsw_status_gen #(
    parameter int NUM_BLOCKS = 7,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            op_kind,
    input  logic                  rd_stb,
    input  logic [BLK_W-1:0]      rd_block,
    input  logic [NUM_BLOCKS-1:0] erase_mask,
    input  logic [NUM_BLOCKS-1:0] fail_mask,
    input  logic                  prog_bit7,
    input  logic                  erase_started,
    input  logic                  fail_set,
    input  logic                  clr_err,
    input  logic [7:0]            array_data,
    output logic [7:0]            rd_data,
    output logic                  busy_n
);
    import fsw_pkg::*;

    typedef struct packed {
        logic              stb_q;
        logic [WORD_W-1:0] word;
        logic              busy_n;
    } top_t;

    top_t st_d, st_q;

    logic rd_evt;
    logic in_erase, in_fail;
    logic err_q, tog_main_q, tog_alt_q;
    logic main_adv, alt_adv, tog_clr, alt_cond;
    logic [WORD_W-1:0] word_c;

    fsw_blk_sel #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_sel (
        .rd_block   (rd_block),
        .erase_mask (erase_mask),
        .fail_mask  (fail_mask),
        .all_sel    (op_kind == OP_CHIP),
        .in_erase   (in_erase),
        .in_fail    (in_fail)
    );

    fsw_err_latch u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fail_set),
        .clr   (clr_err),
        .q     (err_q)
    );

    fsw_toggle u_tog_main (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tog_clr),
        .adv   (main_adv),
        .q     (tog_main_q)
    );

    fsw_toggle u_tog_alt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tog_clr),
        .adv   (alt_adv),
        .q     (tog_alt_q)
    );

    // Read event and toggle control
    always_comb begin
        rd_evt  = rd_stb & ~st_q.stb_q;
        tog_clr = ~op_is_active(op_kind);
        unique case (op_kind)
            OP_CHIP, OP_BLK: alt_cond = err_q ? in_fail : in_erase;
            OP_SUSP:         alt_cond = in_erase;
            default:         alt_cond = 1'b0;
        endcase
        main_adv = rd_evt & op_is_busy(op_kind);
        alt_adv  = rd_evt & alt_cond;
    end

    // Result word selection
    always_comb begin
        word_c = '0;
        unique case (op_kind)
            OP_PROG: begin
                word_c[B_POLL]  = ~prog_bit7;
                word_c[B_TOG]   = tog_main_q;
                word_c[B_FAULT] = err_q;
            end
            OP_CHIP, OP_BLK: begin
                word_c[B_POLL]  = 1'b0;
                word_c[B_TOG]   = tog_main_q;
                word_c[B_FAULT] = err_q;
                word_c[B_TMR]   = (op_kind == OP_CHIP) ? 1'b1 : erase_started;
                word_c[B_ALT]   = tog_alt_q;
            end
            OP_SUSP: begin
                if (in_erase) begin
                    word_c[B_POLL] = 1'b1;
                    word_c[B_TOG]  = tog_main_q;
                    word_c[B_TMR]  = 1'b1;
                    word_c[B_ALT]  = tog_alt_q;
                end else begin
                    word_c = array_data;
                end
            end
            default: word_c = array_data;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.stb_q  = rd_stb;
        st_d.busy_n = ~op_is_busy(op_kind);
        if (rd_evt) st_d.word = word_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stb_q  <= 1'b0;
            st_q.word   <= '0;
            st_q.busy_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.word;
    assign busy_n  = st_q.busy_n;
endmodule

// File: rtl/fsw_status_gen_chk.sv
module fsw_status_gen_chk #(
    parameter int NUM_BLOCKS = 7,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2:0]            op_kind,
    input logic                  prog_bit7,
    input logic                  fail_set,
    input logic                  clr_err,
    input logic [7:0]            rd_data,
    input logic                  busy_n,
    input logic                  rd_evt,
    input logic                  err_q,
    input logic                  tog_main_q,
    input logic                  tog_alt_q,
    input logic                  in_erase
);
    p_prog_poll_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && op_kind == 3'd1) |=> (rd_data[7] == !$past(prog_bit7)));

    p_erase_poll_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && (op_kind == 3'd2 || op_kind == 3'd3)) |=> (rd_data[7] == 1'b0));

    p_tog_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 3'd4) |=> $stable(tog_main_q));

    p_fault_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_err) |=> err_q);

    p_fault_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_set && !clr_err) |=> err_q);

    p_alt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && op_kind == 3'd3 && !err_q && !in_erase) |=> $stable(tog_alt_q));

    p_busy_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 3'd1) |=> !busy_n);

    p_busy_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 3'd0) |=> busy_n);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_evt |=> $stable(rd_data));
endmodule

bind fsw_status_gen fsw_status_gen_chk #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_kind    (op_kind),
    .prog_bit7  (prog_bit7),
    .fail_set   (fail_set),
    .clr_err    (clr_err),
    .rd_data    (rd_data),
    .busy_n     (busy_n),
    .rd_evt     (rd_evt),
    .err_q      (err_q),
    .tog_main_q (tog_main_q),
    .tog_alt_q  (tog_alt_q),
    .in_erase   (in_erase)
);

// File: tb/fsw_status_gen_tb.sv
module fsw_status_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 7;
    localparam int BW = 3;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [2:0]    op_kind = 0;
    logic          rd_stb = 0;
    logic [BW-1:0] rd_block = 0;
    logic [NB-1:0] erase_mask = 0;
    logic [NB-1:0] fail_mask = 0;
    logic          prog_bit7 = 0;
    logic          erase_started = 0;
    logic          fail_set = 0;
    logic          clr_err = 0;
    logic [7:0]    array_data = 0;
    logic [7:0]    rd_data;
    logic          busy_n;

    fsw_status_gen #(.NUM_BLOCKS(NB), .BLK_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .rd_stb(rd_stb),
        .rd_block(rd_block), .erase_mask(erase_mask), .fail_mask(fail_mask),
        .prog_bit7(prog_bit7), .erase_started(erase_started),
        .fail_set(fail_set), .clr_err(clr_err), .array_data(array_data),
        .rd_data(rd_data), .busy_n(busy_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0;
    int    n_errs = 0;
    string cur_req = "R10";
    bit    done = 0;

    // Behavioural reference model
    int m_tog, m_alt, m_err, m_prev, m_busy;
    int m_rd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tog = 0; m_alt = 0; m_err = 0; m_prev = 0; m_busy = 1; m_rd = 0;
        end else begin
            int op, evt, ie, iff_, busy_op, alt_ok, w;
            op  = int'(op_kind);
            evt = (rd_stb && m_prev == 0) ? 1 : 0;
            m_prev = rd_stb ? 1 : 0;
            ie   = (int'(rd_block) < NB) ? int'(erase_mask[rd_block]) : 0;
            iff_ = (int'(rd_block) < NB) ? int'(fail_mask[rd_block]) : 0;
            if (op == 2) ie = 1;
            busy_op = (op >= 1 && op <= 3) ? 1 : 0;
            if (evt != 0) begin
                if (op == 1)
                    w = ((prog_bit7 ? 0 : 1) * 128) + m_tog * 64 + m_err * 32;
                else if (op == 2 || op == 3)
                    w = m_tog * 64 + m_err * 32 + ((op == 2) ? 8 : int'(erase_started) * 8) + m_alt * 4;
                else if (op == 4 && ie != 0)
                    w = 128 + m_tog * 64 + 8 + m_alt * 4;
                else
                    w = int'(array_data);
                m_rd = w;
            end
            if (op == 2 || op == 3) alt_ok = (m_err != 0) ? iff_ : ie;
            else if (op == 4)       alt_ok = ie;
            else                    alt_ok = 0;
            if (op < 1 || op > 4) begin
                m_tog = 0; m_alt = 0;
            end else if (evt != 0) begin
                if (busy_op != 0) m_tog = 1 - m_tog;
                if (alt_ok != 0)  m_alt = 1 - m_alt;
            end
            if (clr_err)       m_err = 0;
            else if (fail_set) m_err = 1;
            m_busy = busy_op != 0 ? 0 : 1;
        end
    end

    task automatic check(input string req, input int got, input int exp, input string what);
        n_checks++;
        if (got != exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, int'(rd_data), m_rd, "rd_data");
            check(cur_req, int'(busy_n), m_busy, "busy_n");
        end
    end

    task automatic rd(input int blk);
        @(negedge clk);
        rd_block = BW'(blk);
        rd_stb = 1;
        @(negedge clk);
        rd_stb = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        idle(2);
        // Reset state: R10 rd_data 0, R8 busy_n 1
        check("R10", int'(rd_data), 0, "reset rd_data");
        check("R8", int'(busy_n), 1, "reset busy_n");
        @(negedge clk); rst_n = 1;
        idle(2);

        // R9: array pass-through in read mode
        cur_req = "R9";
        for (int i = 0; i < 4; i++) begin
            array_data = 8'(8'h3C + 8'(i * 37));
            rd(i);
        end

        // R1: program status, both target values
        cur_req = "R1";
        @(negedge clk); op_kind = 3'd1; prog_bit7 = 1; array_data = 8'hFF;
        rd(0); rd(3);
        @(negedge clk); prog_bit7 = 0;
        rd(5); rd(1);

        // R3: strobe held for several clocks counts once
        cur_req = "R3";
        @(negedge clk); rd_stb = 1;
        idle(4);
        rd_stb = 0;
        rd(2); rd(2);

        // R8: back to read then busy again
        cur_req = "R8";
        @(negedge clk); op_kind = 3'd0;
        idle(2);
        @(negedge clk); op_kind = 3'd3;
        idle(2);

        // R5 / R6: block erase, timer bit and alternate toggle
        cur_req = "R5";
        @(negedge clk); erase_mask = 7'b0010110; erase_started = 0;
        rd(1); rd(0);
        @(negedge clk); erase_started = 1;
        rd(2); rd(4);
        cur_req = "R6";
        for (int i = 0; i < 8; i++) rd(i);
        rd(1); rd(1); rd(6); rd(6);

        // R3 / R2: suspend freezes primary, erasing block reads poll 1
        cur_req = "R2";
        @(negedge clk); op_kind = 3'd4; array_data = 8'h5A;
        rd(1); rd(2); rd(4); rd(1);
        cur_req = "R9";
        rd(0); rd(3); rd(7);
        cur_req = "R3";
        @(negedge clk); op_kind = 3'd3;
        rd(1); rd(0);

        // R2: chip erase
        cur_req = "R2";
        @(negedge clk); op_kind = 3'd2; erase_mask = 7'b0;
        rd(0); rd(6); rd(3);

        // R4: fault flag sets and sticks, clear wins
        cur_req = "R4";
        @(negedge clk); op_kind = 3'd3; erase_mask = 7'b1001101; fail_set = 1;
        @(negedge clk); fail_set = 0;
        rd(0); idle(3); rd(2);
        @(negedge clk); fail_set = 1; clr_err = 1;
        @(negedge clk); fail_set = 0; clr_err = 0;
        rd(0);

        // R7: after erase fault, only failed blocks move bit 2
        cur_req = "R7";
        @(negedge clk); fail_mask = 7'b0001000; fail_set = 1;
        @(negedge clk); fail_set = 0;
        for (int i = 0; i < NB; i++) begin rd(i); rd(i); end
        rd(3); rd(3); rd(0); rd(0);
        @(negedge clk); clr_err = 1;
        @(negedge clk); clr_err = 0;

        // R10: randomized mix
        cur_req = "R10";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 15) == 0) op_kind = 3'($urandom_range(0, 6));
            rd_stb        = 1'($urandom_range(0, 1));
            rd_block      = BW'($urandom_range(0, 7));
            array_data    = 8'($urandom_range(0, 255));
            prog_bit7     = 1'($urandom_range(0, 1));
            erase_started = 1'($urandom_range(0, 1));
            fail_set      = ($urandom_range(0, 31) == 0);
            clr_err       = ($urandom_range(0, 47) == 0);
            if ($urandom_range(0, 63) == 0) erase_mask = NB'($urandom_range(0, 127));
            if ($urandom_range(0, 63) == 0) fail_mask  = NB'($urandom_range(0, 127));
        end
        @(negedge clk); rd_stb = 0; fail_set = 0; clr_err = 0;
        idle(3);
        finish_run();
    end
endmodule